// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the condition flags of a 16-bit integer datapath from the operands and result of each arithmetic or logical operation, and holds them in a 16-bit flags word. The ALU sits outside this block. It presents its two operands, its result, an operation class and a byte/word size select, and it pulses an update strobe. The block then registers the new carry, parity, auxiliary carry, zero, sign and overflow bits.

A separate write port loads the three control bits: single-step, interrupt-enable and direction. Arithmetic and logical updates never change these bits. The flag bits sit at fixed, non-adjacent positions because other logic decodes the word by bit position. All positions that hold no flag read as zero.

Carry, auxiliary carry and overflow are recovered from the operand and result bits at each boundary. Because of this, an add or subtract that included an incoming carry or borrow is flagged correctly without a separate carry-in pin.

Top module: `status_flag_unit`

## Requirements
- R1: Flags bit 0 (carry) is set after an add when a carry leaves the most significant bit of the selected size, and after a subtract when a borrow enters it. Otherwise it is cleared. This includes operations with an incoming carry or borrow, as seen in the result.
- R2: Flags bit 2 (parity) is set when result bits 7..0 hold an even number of ones, in both byte and word size.
- R3: Flags bit 4 (auxiliary) is set after an add on a carry from bit 3 into bit 4, and after a subtract on a borrow into bit 3 from bit 4. Otherwise it is cleared.
- R4: Flags bit 6 (zero) is set exactly when the result of the selected size is zero. Flags bit 7 (sign) equals the result's most significant bit of that size. Byte size uses bits 7..0 and word size uses bits 15..0.
- R5: Flags bit 11 (overflow) is set when the signed add or subtract result does not fit the selected size.
- R6: A logical operation clears carry and overflow, leaves the auxiliary bit unchanged, and updates parity, zero and sign.
- R7: Bits 8, 9 and 10 change only through the control write port. On a write they take ctl_wdata[0], [1] and [2] respectively. An update in the same cycle still updates the status bits.
- R8: The op_cls encoding is 00 add, 01 subtract, 10 logical, and 11 leaves the flags unchanged. byte_sel=1 selects byte size. With upd_en=0 and ctl_we=0 the flags word holds.
- R9: Bits 1, 3, 5 and 15..12 always read zero. Reset clears the whole word.
- R10: A strobe or write sampled at a clock edge is visible on flags_q right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_en | input | 1 | Status update strobe |
| op_cls | input | 2 | Operation class |
| byte_sel | input | 1 | 1 = byte size, 0 = word size |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| ctl_we | input | 1 | Control flag write enable |
| ctl_wdata | input | 3 | {direction, interrupt-enable, single-step} |
| flags_q | output | 16 | Registered flags word |

## Verification
The bench builds the block with its defaults: a 16-bit word, an 8-bit byte lane and a 4-bit nibble boundary. With these values the byte and word lanes both exercise their own carry, sign and overflow points. In byte mode the bench fills the upper result byte with random data, which shows that byte-size flags ignore it. Random incoming carries and borrows reach every combination of boundary carries, and same-cycle control writes show that the two write paths stay independent.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
    localparam int FLAG_W     = 16;
    localparam int CTL_W      = 3;
    localparam int POS_CARRY  = 0;
    localparam int POS_PARITY = 2;
    localparam int POS_AUX    = 4;
    localparam int POS_ZERO   = 6;
    localparam int POS_SIGN   = 7;
    localparam int POS_STEP   = 8;
    localparam int POS_INTEN  = 9;
    localparam int POS_DIR    = 10;
    localparam int POS_OVF    = 11;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGIC = 2'b10,
        OPC_HOLD  = 2'b11
    } op_cls_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic ovf;
    } status_t;

    typedef struct packed {
        logic dir;
        logic inten;
        logic step;
    } ctl_t;

    typedef struct packed {
        status_t st;
        ctl_t    ctl;
    } flag_state_t;
endpackage

// File: rtl/flag_boundary_eval.sv
module flag_boundary_eval (
    input  logic a_bit,
    input  logic b_bit,
    input  logic r_bit,
    input  logic is_sub,
    output logic cout
);
    logic cin_rec;
    logic differ;

    always_comb begin
        cin_rec = a_bit ^ b_bit ^ r_bit;
        differ  = a_bit ^ b_bit;
        if (is_sub) begin
            cout = (~a_bit & b_bit) | (~differ & cin_rec);
        end else begin
            cout = (a_bit & b_bit) | (differ & cin_rec);
        end
    end
endmodule

// File: rtl/flag_parity_tree.sv
module flag_parity_tree #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_i,
    output logic         even_o
);
    logic [W-1:0] acc;

    assign acc[0] = bits_i[0];
    for (genvar g = 1; g < W; g++) begin : g_chain
        assign acc[g] = acc[g-1] ^ bits_i[g];
    end
    assign even_o = ~acc[W-1];
endmodule

// File: rtl/flag_width_lane.sv
module flag_width_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic [LANE_W-1:0] r_i,
    input  logic              is_sub,
    output logic              cout_o,
    output logic              ovf_o,
    output logic              sign_o,
    output logic              zero_o
);
    localparam int MSB = LANE_W - 1;

    flag_boundary_eval msb_eval_i (
        .a_bit (a_i[MSB]),
        .b_bit (b_i[MSB]),
        .r_bit (r_i[MSB]),
        .is_sub(is_sub),
        .cout  (cout_o)
    );

    always_comb begin
        sign_o = r_i[MSB];
        zero_o = (r_i == '0);
        if (is_sub) begin
            ovf_o = (a_i[MSB] != b_i[MSB]) && (r_i[MSB] != a_i[MSB]);
        end else begin
            ovf_o = (a_i[MSB] == b_i[MSB]) && (r_i[MSB] != a_i[MSB]);
        end
    end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_cls,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int N_LANES  = 2;
    localparam int LANE_SEL = 0;

    op_cls_e     op;
    logic        is_sub;
    logic        aux_c;
    logic        par_even;
    logic [N_LANES-1:0] lane_cout;
    logic [N_LANES-1:0] lane_ovf;
    logic [N_LANES-1:0] lane_sign;
    logic [N_LANES-1:0] lane_zero;
    flag_state_t state_d;
    flag_state_t state_q;
    status_t     arith_s;

    assign op     = op_cls_e'(op_cls);
    assign is_sub = (op == OPC_SUB);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == LANE_SEL) ? BYTE_W : DATA_W;
        flag_width_lane #(.LANE_W(LW)) lane_i (
            .a_i   (opa[LW-1:0]),
            .b_i   (opb[LW-1:0]),
            .r_i   (res[LW-1:0]),
            .is_sub(is_sub),
            .cout_o(lane_cout[g]),
            .ovf_o (lane_ovf[g]),
            .sign_o(lane_sign[g]),
            .zero_o(lane_zero[g])
        );
    end

    flag_boundary_eval nib_eval_i (
        .a_bit (opa[NIB_W-1]),
        .b_bit (opb[NIB_W-1]),
        .r_bit (res[NIB_W-1]),
        .is_sub(is_sub),
        .cout  (aux_c)
    );

    flag_parity_tree #(.W(BYTE_W)) par_i (
        .bits_i(res[BYTE_W-1:0]),
        .even_o(par_even)
    );

    always_comb begin
        arith_s.cf  = byte_sel ? lane_cout[0] : lane_cout[1];
        arith_s.ovf = byte_sel ? lane_ovf[0]  : lane_ovf[1];
        arith_s.sf  = byte_sel ? lane_sign[0] : lane_sign[1];
        arith_s.zf  = byte_sel ? lane_zero[0] : lane_zero[1];
        arith_s.af  = aux_c;
        arith_s.pf  = par_even;

        state_d = state_q;
        if (upd_en) begin
            case (op)
                OPC_ADD, OPC_SUB: state_d.st = arith_s;
                OPC_LOGIC: begin
                    state_d.st.cf  = 1'b0;
                    state_d.st.ovf = 1'b0;
                    state_d.st.pf  = arith_s.pf;
                    state_d.st.zf  = arith_s.zf;
                    state_d.st.sf  = arith_s.sf;
                end
                default: ;
            endcase
        end
        if (ctl_we) begin
            state_d.ctl = ctl_t'(ctl_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flags_q             = '0;
        flags_q[POS_CARRY]  = state_q.st.cf;
        flags_q[POS_PARITY] = state_q.st.pf;
        flags_q[POS_AUX]    = state_q.st.af;
        flags_q[POS_ZERO]   = state_q.st.zf;
        flags_q[POS_SIGN]   = state_q.st.sf;
        flags_q[POS_STEP]   = state_q.ctl.step;
        flags_q[POS_INTEN]  = state_q.ctl.inten;
        flags_q[POS_DIR]    = state_q.ctl.dir;
        flags_q[POS_OVF]    = state_q.st.ovf;
    end

    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> flags_q[POS_DIR:POS_STEP] == $past(flags_q[POS_DIR:POS_STEP]));
    p_ctl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> flags_q[POS_DIR:POS_STEP] == $past(ctl_wdata));
    p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b10) |=> (!flags_q[POS_CARRY] && !flags_q[POS_OVF]));
    p_logic_aux_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == 2'b10) |=> flags_q[POS_AUX] == $past(flags_q[POS_AUX]));
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we && (!upd_en || op_cls == 2'b11)) |=> $stable(flags_q));
    p_sign_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != 2'b11 && byte_sel) |=> flags_q[POS_SIGN] == $past(res[BYTE_W-1]));
    p_sign_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != 2'b11 && !byte_sel) |=> flags_q[POS_SIGN] == $past(res[DATA_W-1]));
    p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != 2'b11) |=> flags_q[POS_PARITY] == ~^$past(res[BYTE_W-1:0]));
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & 16'hF02A) == 16'h0000);
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_cls = 2'b00;
    logic        byte_sel = 1'b0;
    logic [15:0] opa = '0, opb = '0, res = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [15:0] flags_q;

    int total = 0;
    int bad = 0;
    logic [15:0] model = '0;

    always #2 clk = ~clk;

    status_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
        .byte_sel(byte_sel), .opa(opa), .opb(opb), .res(res),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .flags_q(flags_q)
    );

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic chk_all(string ctx);
        chk("R1", {ctx, " carry"}, 16'(flags_q[0]), 16'(model[0]));
        chk("R2", {ctx, " parity"}, 16'(flags_q[2]), 16'(model[2]));
        chk("R3", {ctx, " aux"}, 16'(flags_q[4]), 16'(model[4]));
        chk("R4", {ctx, " zero"}, 16'(flags_q[6]), 16'(model[6]));
        chk("R4", {ctx, " sign"}, 16'(flags_q[7]), 16'(model[7]));
        chk("R5", {ctx, " overflow"}, 16'(flags_q[11]), 16'(model[11]));
        chk("R7", {ctx, " control"}, 16'(flags_q[10:8]), 16'(model[10:8]));
        chk("R9", {ctx, " unused"}, flags_q & 16'hF02A, 16'h0000);
    endtask

    // Drive one cycle at the negedge, let the edge pass, compare shortly after (R10)
    task automatic step(string ctx);
        @(posedge clk);
        #1;
        chk_all(ctx);
        @(negedge clk);
        upd_en = 1'b0;
        ctl_we = 1'b0;
    endtask

    // Arithmetic stimulus with expected flags from integer arithmetic
    task automatic arith(bit sub, bit bsel, logic [15:0] a, logic [15:0] b, int cin,
                         logic [7:0] upper, string ctx);
        int w, mask, ua, ub, sa, sb, full, low, ss, nib;
        bit cf, af, of_v;
        w = bsel ? 8 : 16;
        mask = (1 << w) - 1;
        ua = int'(a) & mask;
        ub = int'(b) & mask;
        sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
        sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
        if (sub) begin
            full = ua - ub - cin;
            cf = full < 0;
            nib = (ua & 15) - (ub & 15) - cin;
            af = nib < 0;
            ss = sa - sb - cin;
        end else begin
            full = ua + ub + cin;
            cf = full > mask;
            nib = (ua & 15) + (ub & 15) + cin;
            af = nib > 15;
            ss = sa + sb + cin;
        end
        of_v = (ss > (1 << (w - 1)) - 1) || (ss < -(1 << (w - 1)));
        low = full & mask;
        upd_en = 1'b1;
        op_cls = sub ? 2'b01 : 2'b00;
        byte_sel = bsel;
        opa = a;
        opb = b;
        res = bsel ? {upper, 8'(low)} : 16'(low);
        model[0] = cf;
        model[2] = ~^res[7:0];
        model[4] = af;
        model[6] = (low == 0);
        model[7] = 1'((low >> (w - 1)) & 1);
        model[11] = of_v;
    endtask

    task automatic logic_op(bit bsel, logic [15:0] r);
        upd_en = 1'b1;
        op_cls = 2'b10;
        byte_sel = bsel;
        opa = 16'($urandom);
        opb = 16'($urandom);
        res = r;
        model[0] = 1'b0;
        model[11] = 1'b0;
        model[2] = ~^r[7:0];
        model[6] = bsel ? (r[7:0] == 0) : (r == 0);
        model[7] = bsel ? r[7] : r[15];
    endtask

    task automatic ctl_write(logic [2:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        model[10:8] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk("R9", "flags during reset", flags_q, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "flags after reset", flags_q, 16'h0000);

        arith(0, 0, 16'hFFFF, 16'h0001, 0, 8'h00, "word FFFF+1");
        step("R1 R3 R4 word wrap");
        arith(0, 1, 16'hA57F, 16'h3301, 0, 8'hC3, "byte 7F+1");
        step("R5 R4 byte overflow upper ignored");
        arith(1, 0, 16'h0000, 16'h0001, 0, 8'h00, "word 0-1");
        step("R1 R3 word borrow");
        arith(1, 1, 16'h0080, 16'h0001, 0, 8'h5A, "byte 80-1");
        step("R5 byte sub overflow");
        arith(0, 0, 16'h7FFF, 16'h0000, 1, 8'h00, "word 7FFF+0+c");
        step("R5 R1 carry-in overflow");
        arith(1, 0, 16'h0005, 16'h0005, 1, 8'h00, "word 5-5-b");
        step("R1 borrow-in");

        arith(0, 0, 16'h000F, 16'h0001, 0, 8'h00, "aux set");
        step("R3 aux set before logic");
        logic_op(0, 16'h8000);
        step("R6 logic keeps aux");
        chk("R6", "aux held after logic", 16'(flags_q[4]), 16'h0001);

        ctl_write(3'b101);
        arith(0, 0, 16'h1234, 16'h4321, 0, 8'h00, "same cycle");
        step("R7 write with update");
        chk("R7", "control bits after write", 16'(flags_q[10:8]), 16'h0005);

        upd_en = 1'b1; op_cls = 2'b11; res = 16'h0000; opa = 16'hFFFF; opb = 16'hFFFF;
        step("R8 reserved class holds");
        upd_en = 1'b0; op_cls = 2'b00; res = 16'h0000;
        step("R8 strobe low holds");

        for (int i = 0; i < 4000; i++) begin
            int kind;
            kind = int'($urandom % 8);
            if (($urandom % 6) == 0) ctl_write(3'($urandom));
            case (kind)
                0, 1, 2: arith(0, 1'($urandom), 16'($urandom), 16'($urandom),
                               int'($urandom % 2), 8'($urandom), "rand add");
                3, 4, 5: arith(1, 1'($urandom), 16'($urandom), 16'($urandom),
                               int'($urandom % 2), 8'($urandom), "rand sub");
                6: logic_op(1'($urandom), (($urandom % 4) == 0) ? 16'h0000 : 16'($urandom));
                default: begin
                    upd_en = 1'($urandom);
                    op_cls = 2'b11;
                    res = 16'($urandom);
                end
            endcase
            step("random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule